// File: doc/BRIEF.md
# Dual Reload-Counter Baud Tick Generator

This block derives the bit-timing strobes of a serial interface from the bus clock. It has two down-counters, one for the transmit side and one for the receive side. Both load from one shared 15-bit divisor. Each counter emits a one-cycle strobe once every divisor+1 bus clocks, so the divisor for a wanted rate is f_clk / rate − 1. For example, a 16 MHz clock with a divisor of 39 gives 400 kbps. An 8 MHz clock gives 400 kbps with a divisor of 19 and 100 kbps with a divisor of 79.

Software writes the divisor with one 16-bit access. A write is taken only while the serial function is switched off. An accepted write loads both counters, and they start counting at once. A divisor of zero parks both counters, and no strobes appear. The same 16-bit read path returns the live value of the transmit counter, which lets software watch it count down.

Top module: `baud_reload_gen`

## Requirements
- R1: After reset the divisor is 0, neither strobe is asserted, and the readback value is 0.
- R2: With a nonzero divisor V, each strobe is high for exactly one clock and repeats every V+1 clocks.
- R3: A write with the serial function off loads both counters with V in the clock edge that takes the write. The first strobe follows V clocks after that edge.
- R4: A divisor of 0 stops both counters. No strobe is produced and the readback stays 0.
- R5: The transmit and receive strobes are asserted on the same clocks.
- R6: A write made while serial_en is 1 changes neither the divisor nor the strobe timing.
- R7: Write data bit 15 is dropped, and readback bit 15 is always 0.
- R8: Readback bits 14:0 show the live transmit count. It starts at V, falls by one each clock to 0, then returns to V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serial_en | input | 1 | Serial function enable; while 1, divisor writes are refused |
| wr_en | input | 1 | Divisor write strobe |
| wr_data | input | 16 | Write data; bits 14:0 are the divisor |
| rd_data | output | 16 | Readback: live transmit count in bits 14:0, bit 15 zero |
| tx_tick | output | 1 | Transmit timing strobe |
| rx_tick | output | 1 | Receive timing strobe |

## Verification
Some properties are checked on every clock:
- the count never exceeds the divisor;
- the count steps down by one, and reloads to the divisor after a strobe;
- the divisor holds while serial_en is 1;
- the two strobes agree;
- an accepted write shows up on the readback in the next cycle, with bit 15 dropped.

Other properties can only be shown by the bench's scenarios, because they depend on counting cycles over whole periods:
- the exact spacing of the strobes for several divisors, from 1 up to 1000;
- the delay from a write to the first strobe;
- the parked state after a zero divisor;
- strobe timing that carries on unchanged when a write is refused.

// File: rtl/bgen_pkg.sv
package bgen_pkg;
   localparam int unsigned DIR_COUNT = 2;
   typedef enum int unsigned {
      DIR_TX = 0,
      DIR_RX = 1
   } dir_e;
endpackage

// File: rtl/bgen_reload_reg.sv
module bgen_reload_reg #(
   parameter int unsigned RELOAD_W = 15,
   parameter int unsigned BUS_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                serial_en_i,
   input  logic                wr_en_i,
   input  logic [BUS_W-1:0]    wr_data_i,
   output logic [RELOAD_W-1:0] reload_o,
   output logic                load_o
);
   logic [RELOAD_W-1:0] reload_q;

   // A write is taken only while the serial function is off.
   assign load_o = wr_en_i & ~serial_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reload_q <= '0;
      else if (load_o)
         reload_q <= wr_data_i[RELOAD_W-1:0];
   end

   assign reload_o = reload_q;

   // R6: divisor frozen while serial_en is high
   a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      serial_en_i |=> $stable(reload_o));

   // R7: a high top data bit is dropped, the rest is taken
   a_r7_top_bit_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (load_o && wr_data_i[BUS_W-1]) |=> reload_o == $past(wr_data_i[RELOAD_W-1:0]));
endmodule

// File: rtl/bgen_down_counter.sv
module bgen_down_counter #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] count_o,
   output logic             tick_o
);
   logic [CNT_W-1:0] count_q;
   logic             running;

   assign running = (reload_i != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else if (load_i)
         count_q <= load_val_i;
      else if (running) begin
         if (count_q == '0)
            count_q <= reload_i;
         else
            count_q <= count_q - 1'b1;
      end
   end

   assign count_o = count_q;
   assign tick_o  = running && (count_q == '0);

   // R8: the count stays within the divisor
   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= reload_i);

   // R2: the count steps down by one between strobes
   a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !load_i && count_q != '0) |=> count_q == $past(count_q) - 1'b1);

   // R2: the counter reloads after a strobe
   a_r2_reload_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && !load_i) |=> count_q == $past(reload_i));

   // R4: a parked counter stays at zero
   a_r4_parked: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_i == '0 && !load_i) |=> count_q == '0);
endmodule

// File: rtl/baud_reload_gen.sv
module baud_reload_gen
   import bgen_pkg::*;
#(
   parameter int unsigned RELOAD_W = 15,
   parameter int unsigned BUS_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             serial_en,
   input  logic             wr_en,
   input  logic [BUS_W-1:0] wr_data,
   output logic [BUS_W-1:0] rd_data,
   output logic             tx_tick,
   output logic             rx_tick
);
   localparam int unsigned PAD_W = BUS_W - RELOAD_W;

   generate
      if (RELOAD_W < 1 || RELOAD_W >= BUS_W) begin : g_bad_width
         $error("RELOAD_W must be at least 1 and narrower than BUS_W");
      end
   endgenerate

   logic [RELOAD_W-1:0] reload;
   logic                load;
   logic [RELOAD_W-1:0] cnt  [DIR_COUNT];
   logic                tick [DIR_COUNT];

   bgen_reload_reg #(
      .RELOAD_W(RELOAD_W),
      .BUS_W   (BUS_W)
   ) u_reload (
      .clk        (clk),
      .rst_n      (rst_n),
      .serial_en_i(serial_en),
      .wr_en_i    (wr_en),
      .wr_data_i  (wr_data),
      .reload_o   (reload),
      .load_o     (load)
   );

   generate
      for (genvar d = 0; d < DIR_COUNT; d++) begin : g_dir
         bgen_down_counter #(
            .CNT_W(RELOAD_W)
         ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (load),
            .load_val_i(wr_data[RELOAD_W-1:0]),
            .reload_i  (reload),
            .count_o   (cnt[d]),
            .tick_o    (tick[d])
         );
      end
   endgenerate

   assign tx_tick = tick[DIR_TX];
   assign rx_tick = tick[DIR_RX];
   assign rd_data = {{PAD_W{1'b0}}, cnt[DIR_TX]};

   // R5: both directions strobe together
   a_r5_dirs_agree: assert property (@(posedge clk) disable iff (!rst_n)
      tx_tick == rx_tick);

   // R3: an accepted write restarts the count at the new divisor
   a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> rd_data == {{PAD_W{1'b0}}, $past(wr_data[RELOAD_W-1:0])});

   // R7: the top readback bit is always zero
   a_r7_read_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[BUS_W-1]) |=> !rd_data[BUS_W-1]);
endmodule

// File: tb/tb_baud_reload_gen.sv
module tb_baud_reload_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        serial_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        tx_tick;
   logic        rx_tick;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   baud_reload_gen dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .serial_en(serial_en),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .tx_tick  (tx_tick),
      .rx_tick  (rx_tick)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Ends at the negedge after the edge that takes the write.
   task automatic do_write(input logic [15:0] d);
      @(negedge clk);
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_tick(output int n);
      n = 0;
      while (!tx_tick && n < 70000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic next_period(output int n);
      @(negedge clk);
      n = 1;
      while (!tx_tick && n < 70000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic t_reset();
      int seen = 0;
      check(rd_data == 16'd0, "R1", "readback after reset", rd_data, 0);
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (tx_tick || rx_tick) seen++;
      end
      check(seen == 0, "R1", "strobes after reset", seen, 0);
   endtask

   task automatic t_period(input int v);
      int n;
      do_write(16'(v));
      check(rd_data == 16'(v), "R3", "count right after write", rd_data, v);
      wait_tick(n);
      check(n == v, "R3", "clocks to first strobe", n, v);
      check(rx_tick == tx_tick, "R5", "rx with tx at strobe", rx_tick, tx_tick);
      @(negedge clk);
      check(!tx_tick, "R2", "strobe width one clock", tx_tick, 0);
      for (int k = 0; k < 2; k++) begin
         int m;
         wait_tick(m);
         check(m + 1 == v + 1, "R2", "strobe period", m + 1, v + 1);
         check(rx_tick == tx_tick, "R5", "rx with tx repeat", rx_tick, tx_tick);
         @(negedge clk);
      end
   endtask

   task automatic t_readback();
      do_write(16'd10);
      repeat (3) @(negedge clk);
      check(rd_data == 16'd7, "R8", "live count after 3 clocks", rd_data, 7);
      repeat (7) @(negedge clk);
      check(rd_data == 16'd0 && tx_tick, "R8", "count reaches zero", rd_data, 0);
      @(negedge clk);
      check(rd_data == 16'd10, "R8", "count back to divisor", rd_data, 10);
   endtask

   task automatic t_zero();
      int seen = 0;
      do_write(16'd0);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (tx_tick || rx_tick) seen++;
         if (rd_data != 16'd0) seen++;
      end
      check(seen == 0, "R4", "zero divisor parks counters", seen, 0);
      check(rd_data == 16'd0, "R4", "readback parked", rd_data, 0);
   endtask

   task automatic t_bit15();
      int n;
      do_write(16'h8005);
      check(rd_data == 16'd5, "R7", "top write bit dropped", rd_data, 5);
      check(rd_data[15] == 1'b0, "R7", "readback top bit", rd_data[15], 0);
      wait_tick(n);
      next_period(n);
      check(n == 6, "R7", "period with top bit set", n, 6);
   endtask

   task automatic t_locked();
      int n;
      do_write(16'd6);
      wait_tick(n);
      serial_en = 1'b1;
      do_write(16'd20);
      check(rd_data <= 16'd6, "R6", "refused write not loaded", rd_data, 6);
      wait_tick(n);
      next_period(n);
      check(n == 7, "R6", "period kept under lock", n, 7);
      do_write(16'd0);
      wait_tick(n);
      next_period(n);
      check(n == 7, "R6", "zero refused under lock", n, 7);
      serial_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_period(39);
      t_period(19);
      t_period(79);
      t_period(1);
      t_period(1000);
      t_readback();
      t_zero();
      t_bit15();
      t_locked();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(4 * 190000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule